// File: doc/BRIEF.md
# Dual-Space SDRAM Command Controller

This block sits between a processor-side request stream and up to two SDRAM devices. It turns each read or write request into a sequence of SDRAM commands. Each device has its own chip select. Both devices share the row strobe, column strobe, write enable, bank, address, byte-mask and clock-enable pins.

After reset, the controller initialises both devices together. It then serves one access at a time with a closed-page policy:
- activate the row;
- issue one read or write, with the auto-precharge flag taken from configuration;
- issue an explicit single-bank precharge when that flag is clear.

A periodic timer forces a precharge-all followed by an auto-refresh on both devices. A self-refresh request parks both devices with the clock enable held low.

The row and column widths are chosen at run time, as is the data bus width (16 or 32 bits). These inputs are expected to change only while no access is in flight.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only when all of the following hold:
- the controller is idle;
- initialisation has finished;
- no refresh is pending;
- no self-refresh is requested.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset, both chip selects receive, in this order: one precharge-all, INIT_REFS auto-refreshes, a mode-register write (bank 0), and an extended mode-register write (bank 1, address = EMRS_VAL). `init_done` and `req_ready` stay low until the extended write has been issued.
- R2: Commands are encoded on {ras_n,cas_n,we_n} as follows: activate 011, read 101, write 100, precharge 010, refresh 001, mode write 000. Any cycle with both chip selects high, or with the code 111, is a no-op.
- R3: The word address is split at run time. The column sits in the low bits, the 2-bit bank above it, and the row above the bank. The column width is 8, 9 or 10 bits for `cfg_col_sel` 0, 1 or 2. The row width is 11, 12 or 13 bits for `cfg_row_sel` 0, 1 or 2. An activate carries the row on `sd_a` and the bank on `sd_ba`. A read or write carries the column on `sd_a[9:0]`.
- R4: In a read or write command, `sd_a[10]` equals the `cfg_auto_pre` value captured at acceptance. When it is 0, a single-bank precharge (`sd_a[10]`=0) to the same bank and space follows. When it is 1, no single-bank precharge is issued for that access.
- R5: Space 0 drives `sd_cs_n`=2'b10 and space 1 drives `sd_cs_n`=2'b01 for activate, read, write and single-bank precharge. Initialisation and refresh commands drive 2'b00.
- R6: In a read or write cycle, `sd_dqm_n` equals ~`req_be` when `cfg_bus32`=1. When `cfg_bus32`=0, it equals {2'b11, ~`req_be[1:0]`}. In every other cycle, all mask bits are high.
- R7: The command after an activate comes at least T_RCD cycles later. After a precharge, or a read or write with auto-precharge, the gap is at least T_RP. After an auto-refresh, or after the clock enable rises, the gap is at least T_RC. After a mode write, the gap is at least T_MRD.
- R8: A refresh demand arises every REF_PERIOD cycles. It is served when idle by a precharge-all to both spaces and then an auto-refresh to both spaces.
- R9: A self-refresh request seen while idle issues the refresh code to both spaces, with `sd_cke` low in the same cycle. `sd_cke` stays low and the chip selects stay high while the request is held. `sd_cke` rises in the cycle after the request drops.
- R10: The mode-register word has `sd_a[2:0]`=BURST_CODE and `sd_a[6:4]`=CAS_LAT. `sd_a[9]` is 1 in burst-read/single-write mode (`cfg_burst_wr`=0) and 0 in burst-read/burst-write mode.
- R11: `req_ready` is low during initialisation, during refresh and while self-refresh is requested. A request is accepted only on valid and ready together, and is followed by exactly one activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_row_sel | input | 2 | Row width select: 0=11, 1=12, 2=13 bits |
| cfg_col_sel | input | 2 | Column width select: 0=8, 1=9, 2=10 bits |
| cfg_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_burst_wr | input | 1 | 1 = burst write mode, 0 = single write mode |
| cfg_auto_pre | input | 1 | Auto-precharge select for reads and writes |
| self_ref_req | input | 1 | Hold high to keep devices in self-refresh |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | Target SDRAM space |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables, active high |
| init_done | output | 1 | Initialisation finished |
| sd_cke | output | 1 | Shared clock enable |
| sd_cs_n | output | 2 | Per-space chip selects, active low |
| sd_ras_n | output | 1 | Shared row strobe |
| sd_cas_n | output | 1 | Shared column strobe |
| sd_we_n | output | 1 | Shared write enable |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Multiplexed address |
| sd_dqm_n | output | 4 | Active-low byte masks |

## Verification
The bench builds the controller with T_RCD=3, T_RP=4, T_RC=6, T_MRD=2, CAS_LAT=3, INIT_REFS=2, EMRS_VAL=5 and REF_PERIOD=300. These distinct, unequal delays let a gap check tell each timing rule apart. The short refresh period puts several refresh rounds, and refreshes that hold back waiting requests, within a few thousand cycles. The default ADDR_W of 25 lets an all-ones address reach every row, bank and column bit at the widest setting, and shows truncation at the narrowest.

// File: rtl/sdram_cmd_pkg.sv
`timescale 1ns/1ps
package sdram_cmd_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_INIT, ST_IREF, ST_IMRS, ST_IEMRS, ST_IDLE,
    ST_RW, ST_PRE, ST_REF, ST_SELF, ST_WAIT
  } ctl_state_e;
endpackage

// File: rtl/sdram_addr_map.sv
`timescale 1ns/1ps
module sdram_addr_map #(
  parameter int ROW_MAX = 13,
  parameter int COL_MAX = 10,
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = ROW_MAX + BANK_W + COL_MAX
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         row_sel_i,
  input  logic [1:0]         col_sel_i,
  output logic [ROW_MAX-1:0] row_o,
  output logic [COL_MAX-1:0] col_o,
  output logic [BANK_W-1:0]  bank_o
);
  localparam int IW = 5;
  logic [IW-1:0]      col_bits, row_bits;
  logic [COL_MAX-1:0] col_raw;
  logic [ROW_MAX-1:0] row_raw;

  always_comb begin
    case (col_sel_i)
      2'd0:    col_bits = IW'(8);
      2'd1:    col_bits = IW'(9);
      default: col_bits = IW'(10);
    endcase
    case (row_sel_i)
      2'd0:    row_bits = IW'(11);
      2'd1:    row_bits = IW'(12);
      default: row_bits = IW'(13);
    endcase
    col_raw = COL_MAX'(addr_i);
    bank_o  = BANK_W'(addr_i >> col_bits);
    row_raw = ROW_MAX'(addr_i >> (col_bits + IW'(BANK_W)));
  end

  for (genvar i = 0; i < COL_MAX; i++) begin : g_col
    assign col_o[i] = col_raw[i] && (IW'(i) < col_bits);
  end
  for (genvar i = 0; i < ROW_MAX; i++) begin : g_row
    assign row_o[i] = row_raw[i] && (IW'(i) < row_bits);
  end
endmodule

// File: rtl/sdram_byte_mask.sv
`timescale 1ns/1ps
module sdram_byte_mask #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] be_i,
  input  logic             bus32_i,
  output logic [LANES-1:0] dqm_n_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dqm_n_o[i] = !(be_i[i] && (bus32_i || (i < LANES / 2)));
  end
endmodule

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
module sdram_refresh_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend_o <= 1'b0;
    end else begin
      if (ack_i) pend_o <= 1'b0;
      if (cnt == CW'(PERIOD - 1)) begin
        cnt    <= '0;
        pend_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_MAX    = 13,
  parameter int COL_MAX    = 10,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 3,
  parameter int T_RC       = 7,
  parameter int T_MRD      = 2,
  parameter int REF_PERIOD = 1560,
  parameter int INIT_REFS  = 8,
  parameter int CAS_LAT    = 2,
  parameter int BURST_CODE = 0,
  parameter int EMRS_VAL   = 0,
  localparam int BANK_W    = 2,
  localparam int LANES     = 4,
  localparam int ADDR_W    = ROW_MAX + BANK_W + COL_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_row_sel,
  input  logic [1:0]         cfg_col_sel,
  input  logic               cfg_bus32,
  input  logic               cfg_burst_wr,
  input  logic               cfg_auto_pre,
  input  logic               self_ref_req,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_space,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LANES-1:0]   req_be,
  output logic               init_done,
  output logic               sd_cke,
  output logic [1:0]         sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BANK_W-1:0]  sd_ba,
  output logic [ROW_MAX-1:0] sd_a,
  output logic [LANES-1:0]   sd_dqm_n
);
  localparam int WAIT_W = 8;
  localparam logic [WAIT_W-1:0] W_RCD = WAIT_W'(T_RCD - 2);
  localparam logic [WAIT_W-1:0] W_RP  = WAIT_W'(T_RP - 2);
  localparam logic [WAIT_W-1:0] W_RC  = WAIT_W'(T_RC - 2);
  localparam logic [WAIT_W-1:0] W_MRD = WAIT_W'(T_MRD - 2);
  localparam int IREF_W = $clog2(INIT_REFS + 1);

  ctl_state_e         state, after;
  logic [WAIT_W-1:0]  wcnt;
  logic [IREF_W-1:0]  iref_left;
  sd_cmd_e            cmd_q;
  logic [1:0]         cs_q;
  logic [BANK_W-1:0]  ba_q;
  logic [ROW_MAX-1:0] a_q;
  logic [LANES-1:0]   dqm_q;
  logic               cke_q, init_q;
  logic               lat_space, lat_write, lat_auto;
  logic [LANES-1:0]   lat_be;
  logic [COL_MAX-1:0] lat_col;
  logic [BANK_W-1:0]  lat_bank;

  logic [ROW_MAX-1:0] row_w, mode_word, rw_addr;
  logic [COL_MAX-1:0] col_w;
  logic [BANK_W-1:0]  bank_w;
  logic [LANES-1:0]   dqm_w;
  logic               ref_pend, ref_ack;

  sdram_addr_map #(.ROW_MAX(ROW_MAX), .COL_MAX(COL_MAX), .BANK_W(BANK_W)) u_map (
    .addr_i(req_addr), .row_sel_i(cfg_row_sel), .col_sel_i(cfg_col_sel),
    .row_o(row_w), .col_o(col_w), .bank_o(bank_w));

  sdram_byte_mask #(.LANES(LANES)) u_mask (
    .be_i(lat_be), .bus32_i(cfg_bus32), .dqm_n_o(dqm_w));

  sdram_refresh_timer #(.PERIOD(REF_PERIOD)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .ack_i(ref_ack), .pend_o(ref_pend));

  assign ref_ack   = (state == ST_REF);
  assign req_ready = (state == ST_IDLE) && !ref_pend && !self_ref_req;

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = 3'(BURST_CODE);
    mode_word[6:4] = 3'(CAS_LAT);
    mode_word[9]   = !cfg_burst_wr;
    rw_addr                = '0;
    rw_addr[COL_MAX-1:0]   = lat_col;
    rw_addr[10]            = lat_auto;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INIT;  after <= ST_INIT;  wcnt <= '0;
      iref_left <= IREF_W'(INIT_REFS);
      cmd_q <= CMD_NOP;  cs_q <= 2'b11;  ba_q <= '0;  a_q <= '0;
      dqm_q <= '1;  cke_q <= 1'b1;  init_q <= 1'b0;
      lat_space <= 1'b0;  lat_write <= 1'b0;  lat_auto <= 1'b0;
      lat_be <= '0;  lat_col <= '0;  lat_bank <= '0;
    end else begin
      cmd_q <= CMD_NOP;  cs_q <= 2'b11;  ba_q <= '0;  a_q <= '0;  dqm_q <= '1;
      case (state)
        ST_INIT: begin
          cmd_q <= CMD_PRE;  cs_q <= 2'b00;  a_q[10] <= 1'b1;
          state <= ST_WAIT;  wcnt <= W_RP;  after <= ST_IREF;
        end
        ST_IREF: begin
          cmd_q <= CMD_REF;  cs_q <= 2'b00;
          iref_left <= iref_left - 1'b1;
          state <= ST_WAIT;  wcnt <= W_RC;
          after <= (iref_left == IREF_W'(1)) ? ST_IMRS : ST_IREF;
        end
        ST_IMRS: begin
          cmd_q <= CMD_MRS;  cs_q <= 2'b00;  a_q <= mode_word;
          state <= ST_WAIT;  wcnt <= W_MRD;  after <= ST_IEMRS;
        end
        ST_IEMRS: begin
          cmd_q <= CMD_MRS;  cs_q <= 2'b00;  ba_q <= BANK_W'(1);
          a_q <= ROW_MAX'(EMRS_VAL);  init_q <= 1'b1;
          state <= ST_WAIT;  wcnt <= W_MRD;  after <= ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_PRE;  cs_q <= 2'b00;  a_q[10] <= 1'b1;
            state <= ST_WAIT;  wcnt <= W_RP;  after <= ST_REF;
          end else if (self_ref_req) begin
            cmd_q <= CMD_REF;  cs_q <= 2'b00;  cke_q <= 1'b0;
            state <= ST_SELF;
          end else if (req_valid) begin
            lat_space <= req_space;  lat_write <= req_write;
            lat_auto  <= cfg_auto_pre;  lat_be <= req_be;
            lat_col   <= col_w;  lat_bank <= bank_w;
            cmd_q <= CMD_ACT;  cs_q <= req_space ? 2'b01 : 2'b10;
            ba_q  <= bank_w;  a_q <= row_w;
            state <= ST_WAIT;  wcnt <= W_RCD;  after <= ST_RW;
          end
        end
        ST_RW: begin
          cmd_q <= lat_write ? CMD_WR : CMD_RD;
          cs_q  <= lat_space ? 2'b01 : 2'b10;
          ba_q  <= lat_bank;  a_q <= rw_addr;  dqm_q <= dqm_w;
          state <= ST_WAIT;  wcnt <= W_RP;
          after <= lat_auto ? ST_IDLE : ST_PRE;
        end
        ST_PRE: begin
          cmd_q <= CMD_PRE;  cs_q <= lat_space ? 2'b01 : 2'b10;  ba_q <= lat_bank;
          state <= ST_WAIT;  wcnt <= W_RP;  after <= ST_IDLE;
        end
        ST_REF: begin
          cmd_q <= CMD_REF;  cs_q <= 2'b00;
          state <= ST_WAIT;  wcnt <= W_RC;  after <= ST_IDLE;
        end
        ST_SELF: begin
          if (!self_ref_req) begin
            cke_q <= 1'b1;
            state <= ST_WAIT;  wcnt <= W_RC;  after <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (wcnt == '0) state <= after;
          else            wcnt  <= wcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign init_done = init_q;
  assign sd_cke    = cke_q;
  assign sd_cs_n   = cs_q;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dqm_n  = dqm_q;

  // R11
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (init_done && sd_cke));
  // R5
  rw_one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_ras_n && !sd_cas_n && sd_cs_n != 2'b11) |-> ($countones(sd_cs_n) == 1));
  // R9
  cke_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cke && !$past(sd_cke)) |-> (sd_cs_n == 2'b11));
  // R6
  dqm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_ras_n && !sd_cas_n && sd_cs_n != 2'b11) |-> (sd_dqm_n == '1));
endmodule

// File: tb/sdram_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_bench;
  localparam int T_RCD = 3, T_RP = 4, T_RC = 6, T_MRD = 2;
  localparam int REF_PERIOD = 300, INIT_REFS = 2, CAS_LAT = 3, EMRS_VAL = 5;
  localparam int AW = 25;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_row_sel = 2, cfg_col_sel = 2;
  logic cfg_bus32 = 1, cfg_burst_wr = 0, cfg_auto_pre = 0, self_ref_req = 0;
  logic req_valid = 0, req_write = 0, req_space = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic req_ready, init_done, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_cs_n, sd_ba;
  logic [12:0] sd_a;
  logic [3:0] sd_dqm_n;

  sdram_cmd_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .REF_PERIOD(REF_PERIOD), .INIT_REFS(INIT_REFS), .CAS_LAT(CAS_LAT),
    .BURST_CODE(0), .EMRS_VAL(EMRS_VAL)) u_sdram_cmd_ctrl (
    .clk, .rst_n, .cfg_row_sel, .cfg_col_sel, .cfg_bus32, .cfg_burst_wr,
    .cfg_auto_pre, .self_ref_req, .req_valid, .req_ready, .req_write, .req_space,
    .req_addr, .req_be, .init_done, .sd_cke, .sd_cs_n, .sd_ras_n, .sd_cas_n,
    .sd_we_n, .sd_ba, .sd_a, .sd_dqm_n);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: timing gaps (R7), mask idle (R6), refresh order (R8)
  int last_cyc = -1000, need = 0, ref_cnt = 0, pre_single_cnt = 0;
  logic prev_cke = 1, prev_pall = 0;
  always @(negedge clk) if (rst_n) begin
    logic [2:0] c;
    logic v;
    c = {sd_ras_n, sd_cas_n, sd_we_n};
    v = (sd_cs_n != 2'b11) && (c != 3'b111);
    if (!prev_cke && sd_cke) begin last_cyc = cyc; need = T_RC; end
    prev_cke = sd_cke;
    if (!(v && (c == 3'b100 || c == 3'b101)) && sd_dqm_n != 4'hF)
      chk(0, "R6", "mask outside access", sd_dqm_n, 4'hF);
    if (v) begin
      chk(cyc - last_cyc >= need, "R7", "command gap", cyc - last_cyc, need);
      if (c == 3'b001 && sd_cke && init_done && sd_cs_n == 2'b00) begin
        ref_cnt++;
        chk(prev_pall, "R8", "precharge-all before refresh", 0, 1);
      end
      if (c == 3'b010 && !sd_a[10] && sd_cs_n != 2'b00) pre_single_cnt++;
      prev_pall = (c == 3'b010) && sd_a[10] && (sd_cs_n == 2'b00);
      last_cyc = cyc;
      case (c)
        3'b011:         need = T_RCD;
        3'b010:         need = T_RP;
        3'b001:         need = T_RC;
        3'b000:         need = T_MRD;
        default:        need = sd_a[10] ? T_RP : 1;
      endcase
    end
  end

  logic [2:0] g_cmd;
  logic [1:0] g_cs, g_ba;
  logic [12:0] g_a;
  logic [3:0] g_dqm;
  logic g_cke;

  task automatic get_cmd(input bit skip_both);
    bit got = 0;
    int n = 0;
    while (!got && n < 3000) begin
      @(negedge clk);
      n++;
      if (sd_cs_n != 2'b11 && {sd_ras_n, sd_cas_n, sd_we_n} != 3'b111 &&
          !(skip_both && sd_cs_n == 2'b00)) begin
        got = 1;
        g_cmd = {sd_ras_n, sd_cas_n, sd_we_n};
        g_cs = sd_cs_n; g_ba = sd_ba; g_a = sd_a; g_dqm = sd_dqm_n; g_cke = sd_cke;
      end
    end
    if (!got) begin
      g_cmd = 3'b111;
      chk(0, "R7", "command timeout", 0, 1);
    end
  endtask

  function automatic int cbits(input logic [1:0] s);
    return (s == 0) ? 8 : (s == 1) ? 9 : 10;
  endfunction
  function automatic int rbits(input logic [1:0] s);
    return (s == 0) ? 11 : (s == 1) ? 12 : 13;
  endfunction

  task automatic do_access(input bit sp, input bit wr, input bit ap, input bit b32,
                           input logic [1:0] rs, input logic [1:0] cs,
                           input logic [AW-1:0] addr, input logic [3:0] be);
    int cb, rb, pre0, n;
    logic [31:0] ecol, ebank, erow;
    logic [3:0] edqm;
    logic [1:0] ecs;
    @(negedge clk);
    cfg_bus32 = b32; cfg_auto_pre = ap; cfg_row_sel = rs; cfg_col_sel = cs;
    req_space = sp; req_write = wr; req_addr = addr; req_be = be; req_valid = 1;
    while (!req_ready) @(negedge clk);
    pre0 = pre_single_cnt;
    @(posedge clk); #1 req_valid = 0;
    cb = cbits(cs); rb = rbits(rs);
    ecol  = 32'(addr) % (32'd1 << cb);
    ebank = (32'(addr) >> cb) % 4;
    erow  = (32'(addr) >> (cb + 2)) % (32'd1 << rb);
    edqm  = b32 ? ~be : {2'b11, ~be[1:0]};
    ecs   = sp ? 2'b01 : 2'b10;
    get_cmd(1);
    chk(g_cmd == 3'b011, "R11", "activate after accept", g_cmd, 3'b011);
    chk(g_cs == ecs, "R5", "activate chip select", g_cs, ecs);
    chk(g_ba == ebank[1:0], "R3", "activate bank", g_ba, ebank);
    chk(32'(g_a) == erow, "R3", "activate row", g_a, erow);
    get_cmd(1);
    chk(g_cmd == (wr ? 3'b100 : 3'b101), "R2", "read/write code", g_cmd, wr ? 3'b100 : 3'b101);
    chk(g_cs == ecs && g_ba == ebank[1:0], "R5", "access space/bank", {g_cs, g_ba}, {ecs, ebank[1:0]});
    chk(32'(g_a[9:0]) == ecol, "R3", "column", g_a[9:0], ecol);
    chk(g_a[10] == ap, "R4", "auto-precharge bit", g_a[10], ap);
    chk(g_dqm == edqm, "R6", "byte mask", g_dqm, edqm);
    if (!ap) begin
      get_cmd(1);
      chk(g_cmd == 3'b010 && !g_a[10] && g_cs == ecs && g_ba == ebank[1:0],
          "R4", "explicit precharge", {g_cmd, g_a[10], g_cs, g_ba}, {3'b010, 1'b0, ecs, ebank[1:0]});
    end else begin
      n = 0;
      while (!req_ready && n < 2000) begin @(negedge clk); n++; end
      chk(pre_single_cnt == pre0, "R4", "no precharge with auto", pre_single_cnt - pre0, 0);
    end
  endtask

  initial begin
    #(8 * 190000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(sd_cs_n == 2'b11 && sd_cke && !init_done && !req_ready, "R1", "reset state",
        {sd_cs_n, sd_cke, init_done, req_ready}, 5'b11100);
    rst_n = 1;
    req_valid = 1;
    get_cmd(0);
    chk(g_cmd == 3'b010 && g_a[10] && g_cs == 2'b00, "R1", "init precharge-all",
        {g_cmd, g_a[10], g_cs}, 6'b010100);
    for (int i = 0; i < INIT_REFS; i++) begin
      get_cmd(0);
      chk(g_cmd == 3'b001 && g_cs == 2'b00 && !req_ready, "R1", "init refresh",
          {g_cmd, g_cs, req_ready}, 6'b001000);
    end
    get_cmd(0);
    chk(g_cmd == 3'b000 && g_ba == 2'd0 && g_cs == 2'b00, "R1", "mode write", {g_cmd, g_ba}, 5'b00000);
    chk(g_a[2:0] == 3'd0 && g_a[6:4] == 3'(CAS_LAT) && g_a[9] == 1'b1, "R10", "mode word",
        g_a, 13'h230);
    chk(!init_done && !req_ready, "R11", "not ready before extended write", {init_done, req_ready}, 0);
    get_cmd(0);
    chk(g_cmd == 3'b000 && g_ba == 2'd1 && g_a == 13'(EMRS_VAL), "R1", "extended mode write",
        {g_cmd, g_ba, g_a}, {3'b000, 2'd1, 13'(EMRS_VAL)});
    @(negedge clk);
    chk(init_done, "R1", "init done", init_done, 1);
    req_valid = 0;

    // directed corners
    do_access(0, 0, 0, 1, 2, 2, '1, 4'hF);
    do_access(1, 1, 1, 1, 0, 0, '1, 4'h5);
    do_access(1, 1, 0, 0, 1, 1, 25'h0ABCDE, 4'hF);
    do_access(0, 0, 1, 0, 2, 0, 25'h1234567, 4'h6);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] rs, cs;
      rs = 2'($urandom % 3); cs = 2'($urandom % 3);
      do_access(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rs, cs,
                AW'($urandom), 4'($urandom));
    end

    // refresh while idle
    r0 = ref_cnt;
    repeat (700) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R8", "periodic refresh count", ref_cnt - r0, 2);

    // self-refresh with a blocked request
    @(negedge clk);
    self_ref_req = 1;
    begin
      int n = 0;
      do begin get_cmd(0); n++; end while (g_cke && n < 10);
    end
    chk(g_cmd == 3'b001 && g_cs == 2'b00 && !g_cke, "R9", "self-refresh entry",
        {g_cmd, g_cs, g_cke}, 6'b001000);
    req_valid = 1; req_space = 0; req_addr = '0; req_be = 4'hF;
    repeat (20) begin
      @(negedge clk);
      chk(!sd_cke && sd_cs_n == 2'b11 && !req_ready, "R9", "held in self-refresh",
          {sd_cke, sd_cs_n, req_ready}, 4'b0110);
    end
    req_valid = 0;
    self_ref_req = 0;
    @(negedge clk);
    @(negedge clk);
    chk(sd_cke, "R9", "clock enable restored", sd_cke, 1);
    do_access(0, 1, 0, 1, 1, 1, 25'h00F0F0, 4'h9);

    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule